// File: doc/BRIEF.md
# Warp Issue Scheduler

This block keeps track of the warps resident in one streaming multiprocessor and decides which of them feeds its next instruction to a narrow group of SIMD lanes. A warp of 32 threads runs on 8 lanes, so every warp instruction takes 4 back-to-back passes. The block emits a slot of 4 passes at a time, and each slot carries a warp number and a pass index. Between slots it can move to any other eligible warp with no idle cycle. All resident warps run one shared program, so the block selects only a warp and never a kernel.

Each warp slot has two bits: resident and waiting. A launch makes a warp resident and eligible. A done event frees the slot. When a warp sends out a memory load, it is parked until a memory response tagged with its number comes back. At every slot boundary the block picks the first eligible warp in round-robin order, starting after the warp that issued last. If no warp is eligible, it leaves that slot empty and tries again at the next boundary.

Top module: `warp_issue_sched`

## Requirements
- R1: A launch of warp number w (5 bits, 0 to 31) makes w resident and not waiting, so w can be chosen at the next boundary.
- R2: `issue_pass` counts 0, 1, 2, 3 and then returns to 0. A boundary is a cycle with pass 3. `issue_valid` and `issue_wid` change only on the edge that ends such a cycle.
- R3: Among eligible warps, the pick is the first one found going upward from the last issued warp plus one, wrapping from 31 to 0. The warp issued last is the lowest priority.
- R4: If any warp is eligible at a boundary, the next cycle shows `issue_valid` high with pass 0, even when the warp number changes. No empty cycle is inserted.
- R5: After `load_valid` is seen for warp w, w is never issued again until a response tagged w has been seen.
- R6: A load and a response for the same warp in the same cycle leave that warp waiting.
- R7: `done_valid` for warp w removes w from the pool. A launch of w in the same cycle wins, and w stays resident.
- R8: If no warp is eligible at a boundary, `issue_valid` is low for all 4 passes of the following slot.
- R9: During and after reset, `issue_valid` is 0, `issue_pass` is 3 and no warp is resident. The first round-robin search starts at warp 0.
- R10: Launch, done, load and response events presented in the boundary cycle itself are applied before the pick made at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| launch_valid | input | 1 | Make a warp resident |
| launch_wid | input | 5 | Warp number to launch |
| done_valid | input | 1 | Retire a warp |
| done_wid | input | 5 | Warp number to retire |
| load_valid | input | 1 | A warp has sent a memory load |
| load_wid | input | 5 | Warp number that sent the load |
| resp_valid | input | 1 | Memory data is back |
| resp_wid | input | 5 | Warp number tag on the response |
| issue_valid | output | 1 | The current pass carries a warp instruction |
| issue_wid | output | 5 | Warp number of the current slot |
| issue_pass | output | 2 | Pass index inside the slot, 0 to 3 |

## Verification
Warp events are registered on the next clock edge. They affect the issue outputs only at the edge that ends a pass-3 cycle. A pick then shows on `issue_valid` and `issue_wid` exactly one cycle after that boundary, at pass 0, and holds for four cycles. The bench drives every event just after a falling edge. On each rising edge it updates an arithmetic model of the resident and waiting bits and of the round-robin pointer, and it compares the outputs at the following falling edge. A comparison is therefore made one cycle after each stimulus, and every cycle of every slot is checked, not only the boundaries.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  // Default shape of one multiprocessor's issue front end
  localparam int unsigned DEF_NUM_WARPS    = 32;
  localparam int unsigned DEF_WARP_THREADS = 32;
  localparam int unsigned DEF_LANES        = 8;

  // Per-warp bookkeeping bits
  typedef struct packed {
    logic resident;
    logic waiting;
  } warp_flags_t;
endpackage

// File: rtl/warp_state_table.sv
module warp_state_table
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_NUM_WARPS,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_wid,
  input  logic                 done_valid,
  input  logic [WID_W-1:0]     done_wid,
  input  logic                 load_valid,
  input  logic [WID_W-1:0]     load_wid,
  input  logic                 resp_valid,
  input  logic [WID_W-1:0]     resp_wid,
  output logic [NUM_WARPS-1:0] waiting_q,
  output logic [NUM_WARPS-1:0] ready_nxt
);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    warp_flags_t flags_q, flags_d;
    logic launch_hit, done_hit, load_hit, resp_hit;

    always_comb begin
      launch_hit = launch_valid && (launch_wid == WID_W'(w));
      done_hit   = done_valid   && (done_wid   == WID_W'(w));
      load_hit   = load_valid   && (load_wid   == WID_W'(w));
      resp_hit   = resp_valid   && (resp_wid   == WID_W'(w));
      flags_d    = flags_q;
      // launch beats done for slot reuse in the same cycle
      if (launch_hit)    flags_d.resident = 1'b1;
      else if (done_hit) flags_d.resident = 1'b0;
      // a new load beats a response arriving in the same cycle
      if (load_hit)                     flags_d.waiting = 1'b1;
      else if (resp_hit || launch_hit)  flags_d.waiting = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q <= '0;
      end else begin
        flags_q <= flags_d;
      end
    end

    assign waiting_q[w] = flags_q.waiting;
    assign ready_nxt[w] = flags_d.resident & ~flags_d.waiting;
  end

endmodule

// File: rtl/rr_warp_picker.sv
module rr_warp_picker #(
  parameter int unsigned NUM_WARPS = 32,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic [WID_W-1:0]     last_wid,
  output logic                 found,
  output logic [WID_W-1:0]     pick_wid
);

  always_comb begin
    found    = 1'b0;
    pick_wid = last_wid;
    // scan from last+1 upward; the last issued warp is tried at the very end
    for (int unsigned i = 1; i <= NUM_WARPS; i++) begin
      int unsigned idx;
      idx = (int'(last_wid) + i) % NUM_WARPS;
      if (!found && eligible[idx]) begin
        found    = 1'b1;
        pick_wid = WID_W'(idx);
      end
    end
  end

endmodule

// File: rtl/issue_slot.sv
module issue_slot #(
  parameter int unsigned NUM_WARPS = 32,
  parameter int unsigned PASSES    = 4,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS),
  localparam int unsigned PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1,
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              found,
  input  logic [WID_W-1:0]  pick_wid,
  output logic              issue_valid,
  output logic [WID_W-1:0]  issue_wid,
  output logic [PASS_W-1:0] issue_pass
);

  logic              boundary;
  logic              wid_en;
  logic              valid_d;
  logic [PASS_W-1:0] pass_d;

  always_comb begin
    boundary = (issue_pass == LAST_PASS);
    wid_en   = boundary && found;
    valid_d  = boundary ? found : issue_valid;
    pass_d   = boundary ? '0 : issue_pass + PASS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_pass  <= LAST_PASS;
      issue_valid <= 1'b0;
    end else begin
      issue_pass  <= pass_d;
      issue_valid <= valid_d;
    end
  end

  // the warp number doubles as the round-robin pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_wid <= WID_W'(NUM_WARPS - 1);
    end else if (wid_en) begin
      issue_wid <= pick_wid;
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS    = DEF_NUM_WARPS,
  parameter int unsigned WARP_THREADS = DEF_WARP_THREADS,
  parameter int unsigned LANES        = DEF_LANES,
  localparam int unsigned PASSES      = WARP_THREADS / LANES,
  localparam int unsigned WID_W       = $clog2(NUM_WARPS),
  localparam int unsigned PASS_W      = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [WID_W-1:0]  launch_wid,
  input  logic              done_valid,
  input  logic [WID_W-1:0]  done_wid,
  input  logic              load_valid,
  input  logic [WID_W-1:0]  load_wid,
  input  logic              resp_valid,
  input  logic [WID_W-1:0]  resp_wid,
  output logic              issue_valid,
  output logic [WID_W-1:0]  issue_wid,
  output logic [PASS_W-1:0] issue_pass
);

  logic [NUM_WARPS-1:0] waiting_q;
  logic [NUM_WARPS-1:0] ready_nxt;
  logic                 found;
  logic [WID_W-1:0]     pick_wid;

  warp_state_table #(.NUM_WARPS(NUM_WARPS)) i_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_valid (launch_valid),
    .launch_wid   (launch_wid),
    .done_valid   (done_valid),
    .done_wid     (done_wid),
    .load_valid   (load_valid),
    .load_wid     (load_wid),
    .resp_valid   (resp_valid),
    .resp_wid     (resp_wid),
    .waiting_q    (waiting_q),
    .ready_nxt    (ready_nxt)
  );

  rr_warp_picker #(.NUM_WARPS(NUM_WARPS)) i_pick (
    .eligible (ready_nxt),
    .last_wid (issue_wid),
    .found    (found),
    .pick_wid (pick_wid)
  );

  issue_slot #(.NUM_WARPS(NUM_WARPS), .PASSES(PASSES)) i_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .found       (found),
    .pick_wid    (pick_wid),
    .issue_valid (issue_valid),
    .issue_wid   (issue_wid),
    .issue_pass  (issue_pass)
  );

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned NUM_WARPS = 32,
  parameter int unsigned PASSES    = 4,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS),
  localparam int unsigned PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_valid,
  input logic [WID_W-1:0]     load_wid,
  input logic                 resp_valid,
  input logic [WID_W-1:0]     resp_wid,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_wid,
  input logic [PASS_W-1:0]    issue_pass,
  input logic [NUM_WARPS-1:0] waiting,
  input logic [NUM_WARPS-1:0] ready_nxt
);
  localparam logic [PASS_W-1:0] LAST = PASS_W'(PASSES - 1);

  assert_pass_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pass != LAST) |=> (issue_pass == $past(issue_pass) + PASS_W'(1)));

  assert_pass_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pass == LAST) |=> (issue_pass == '0));

  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pass != LAST) |=> ($stable(issue_valid) && $stable(issue_wid)));

  assert_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_pass == LAST) && (|ready_nxt)) |=> issue_valid);

  assert_idle_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_pass == LAST) && !(|ready_nxt)) |=> !issue_valid);

  assert_parked_not_issued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (issue_pass == '0)) |-> !waiting[issue_wid]);

  assert_load_beats_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && resp_valid && (load_wid == resp_wid)) |=> waiting[$past(load_wid)]);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .PASSES    (PASSES)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_valid  (load_valid),
  .load_wid    (load_wid),
  .resp_valid  (resp_valid),
  .resp_wid    (resp_wid),
  .issue_valid (issue_valid),
  .issue_wid   (issue_wid),
  .issue_pass  (issue_pass),
  .waiting     (waiting_q),
  .ready_nxt   (ready_nxt)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 32;

  logic       clk;
  logic       rst_n;
  logic       launch_valid, done_valid, load_valid, resp_valid;
  logic [4:0] launch_wid, done_wid, load_wid, resp_wid;
  logic       issue_valid;
  logic [4:0] issue_wid;
  logic [1:0] issue_pass;

  warp_issue_sched i_warp_issue_sched (
    .clk, .rst_n,
    .launch_valid, .launch_wid, .done_valid, .done_wid,
    .load_valid, .load_wid, .resp_valid, .resp_wid,
    .issue_valid, .issue_wid, .issue_pass
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R9";

  // reference model
  bit       m_res  [NW];
  bit       m_wait [NW];
  int       m_last;
  int       m_pass;
  bit       m_valid;
  int       m_wid;
  logic [15:0] lfsr = 16'hACE1;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (resp_valid) m_wait[resp_wid] = 0;
    if (launch_valid) begin m_res[launch_wid] = 1; m_wait[launch_wid] = 0; end
    if (done_valid && !(launch_valid && launch_wid == done_wid)) m_res[done_wid] = 0;
    if (load_valid) m_wait[load_wid] = 1;
    if (m_pass == 3) begin
      bit hit = 0;
      for (int i = 1; i <= NW; i++) begin
        int idx = (m_last + i) % NW;
        if (!hit && m_res[idx] && !m_wait[idx]) begin
          hit = 1; m_wid = idx; m_last = idx;
        end
      end
      m_valid = hit;
      m_pass = 0;
    end else begin
      m_pass++;
    end
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic cyc(bit lv = 0, int lw = 0, bit dv = 0, int dw = 0,
                     bit ldv = 0, int ldw = 0, bit rv = 0, int rw = 0);
    launch_valid = lv; launch_wid = 5'(lw);
    done_valid   = dv; done_wid   = 5'(dw);
    load_valid   = ldv; load_wid  = 5'(ldw);
    resp_valid   = rv; resp_wid   = 5'(rw);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    launch_valid = 0; done_valid = 0; load_valid = 0; resp_valid = 0;
    check("R2", int'(issue_pass), m_pass, "issue_pass");
    check(tag, int'(issue_valid), int'(m_valid), "issue_valid");
    if (m_valid) check(tag, int'(issue_wid), m_wid, "issue_wid");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    launch_valid = 0; done_valid = 0; load_valid = 0; resp_valid = 0;
    launch_wid = 0; done_wid = 0; load_wid = 0; resp_wid = 0;
    for (int i = 0; i < NW; i++) begin m_res[i] = 0; m_wait[i] = 0; end
    m_last = NW - 1; m_pass = 3; m_valid = 0; m_wid = 0;
    repeat (3) @(negedge clk);
    // R9: reset values
    check("R9", int'(issue_valid), 0, "issue_valid in reset");
    check("R9", int'(issue_pass), 3, "issue_pass in reset");
    rst_n = 1;

    // R10: launch presented in the boundary cycle is picked at its edge
    tag = "R10";
    cyc(1, 0);
    check("R10", int'(issue_valid), 1, "launch at boundary issues next cycle");
    check("R10", int'(issue_wid), 0, "first pick starts at warp 0");
    idle(3);

    // R8: nothing else runs idle after warp 0 is retired
    tag = "R8";
    cyc(0, 0, 1, 0);
    idle(11);

    // R1 and R3: three resident warps with wrap from 31 to 0
    tag = "R1";
    cyc(1, 0); cyc(1, 5); cyc(1, 31);
    tag = "R3";
    idle(24);

    // R5: parked warp 5 is skipped until its response
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 5);
    idle(14);
    cyc(0, 0, 0, 0, 0, 0, 1, 5);
    idle(10);

    // R6: same-cycle load and response leave warp 0 waiting
    tag = "R6";
    cyc(0, 0, 0, 0, 1, 0, 1, 0);
    idle(14);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle(6);

    // R7: launch wins over done, then a plain done retires warp 31
    tag = "R7";
    cyc(1, 31, 1, 31);
    idle(10);
    cyc(0, 0, 1, 31);
    idle(10);

    // R4: full pool with pseudo-random loads, responses, launches and retirements
    tag = "R4";
    for (int w = 0; w < NW; w++) cyc(1, w);
    for (int i = 0; i < 800; i++) begin
      bit lv, dv, ldv, rv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lv  = lfsr[0] & lfsr[1] & lfsr[2];
      dv  = lfsr[3] & lfsr[4] & lfsr[5] & lfsr[6];
      ldv = lfsr[7];
      rv  = lfsr[8] | lfsr[9];
      cyc(lv, int'(lfsr[15:11]), dv, int'(lfsr[12:8]),
          ldv, int'(lfsr[4:0]), rv, int'(lfsr[10:6]));
    end

    // R8: retire everything, slots must go empty
    tag = "R8";
    for (int w = 0; w < NW; w++) cyc(0, 0, 1, w);
    idle(12);
    check("R8", int'(issue_valid), 0, "empty pool leaves slot empty");

    finish_run();
  end
endmodule